// File: doc/BRIEF.md
# Single-Step Debug Exception Generator

This block watches the instruction retirement stream of a core and raises a single-step debug exception each time the core finishes one execution step outside debug mode. An execution step is either a single instruction, or a jump/branch taken together with the instruction in its delay slot. The request is raised at the boundary after the step. It carries the PC of the next instruction to execute, which is also the return address for the debug handler, together with a delay-slot flag that is always clear.

The core reports each retirement with a valid strobe, branch and delay-slot flags, and the PC that follows the retiring instruction. A retiring branch leaves the step open until its delay-slot instruction retires. After a return from debug mode, the first step runs to completion with no request. Once a request has been raised, no further request follows until the next debug return. If the enable bit drops at any point while a step is open, that step produces no request.

Top module: `single_step_gen`

## Requirements
- R1: No request is raised for a step that completes while `step_en_i` is low or `debug_mode_i` is high. Retirements seen while `debug_mode_i` is high are ignored.
- R2: A retirement with `retire_branch_i`=0 and no open step completes a step. With the step enabled, `step_exc_o` is high in the cycle after that retirement is sampled, and `step_epc_o` equals the `retire_next_pc_i` of that retirement.
- R3: A retirement with `retire_branch_i`=1 and `retire_dslot_i`=0 opens a step and raises no request. The step closes at the next retirement, and any request then carries that retirement's `retire_next_pc_i` (the branch target), never the PC of the delay slot.
- R4: `step_epc_o` changes only in the cycle in which `step_exc_o` is high. It holds its value otherwise and resets to zero.
- R5: `step_dbd_o` is always 0.
- R6: After `deret_i`, the first completed step raises no request. The step after it does.
- R7: `step_exc_o` is high for exactly one cycle per request. After a request, no further request is raised until `deret_i`.
- R8: If `step_en_i` is low in any cycle while a step is open (including the cycle in which the branch retires), that step raises no request. The following step is unaffected.
- R9: After reset, `step_exc_o`=0 and `step_epc_o`=0, no step is open, and the first enabled step already raises a request.
- R10: A retirement with `retire_dslot_i`=1 always closes a step, even when no branch opened one and even if `retire_branch_i` is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_branch_i | input | 1 | Retiring instruction is a jump/branch |
| retire_dslot_i | input | 1 | Retiring instruction sits in a delay slot |
| retire_next_pc_i | input | PC_W | PC of the instruction that follows the retiring one |
| step_en_i | input | 1 | Single-step enable |
| debug_mode_i | input | 1 | Core is in debug mode |
| deret_i | input | 1 | Return from debug mode, one-cycle pulse |
| step_exc_o | output | 1 | Single-step exception request, one-cycle pulse |
| step_epc_o | output | PC_W | Return PC to record with the request |
| step_dbd_o | output | 1 | Delay-slot flag to record (always 0) |

## Verification
The bench sweeps a branch step with and without an idle gap before the delay slot, over every pattern of the enable bit across the branch, the gap and the slot. A design that closed the step at the branch would fire with the delay-slot PC. A design that sampled the enable bit only at completion would let a step fire after the enable bit dropped mid-step. Each sweep case starts from a debug return, so a design that fires on the first step after the return, or that fires twice before the next return, shows up as an extra pulse. Lone delay-slot retirements and retirements made in debug mode are also checked. A design that waited for a branch before closing a step, or that counted instructions in debug mode, would be caught there.

// File: rtl/ss_pkg.sv
`timescale 1ns/1ps
package ss_pkg;
  typedef struct packed {
    logic valid;
    logic branch;
    logic dslot;
  } retire_t;
endpackage

// File: rtl/ss_step_tracker.sv
`timescale 1ns/1ps
module ss_step_tracker
  import ss_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  retire_t ret_i,
  input  logic    en_i,
  input  logic    dbg_i,
  input  logic    deret_i,
  output logic    step_done_o,
  output logic    drop_o
);
  logic pend_q, drop_q;
  logic retire_ok, opens;

  assign retire_ok   = ret_i.valid & ~dbg_i;
  // dslot flag overrides branch: a slot instruction never opens a step
  assign opens       = retire_ok & ret_i.branch & ~ret_i.dslot;
  assign step_done_o = retire_ok & ~opens & ~deret_i;
  assign drop_o      = drop_q | (pend_q & ~en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else if (deret_i) begin
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else if (opens) begin
      pend_q <= 1'b1;
      drop_q <= ~en_i;
    end else if (step_done_o) begin
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else if (pend_q && !en_i) begin
      drop_q <= 1'b1;
    end
  end

  AST_BRANCH_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i.valid && ret_i.branch && !ret_i.dslot && !dbg_i && !deret_i) |=> pend_q); // R3

  AST_SLOT_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i.valid && ret_i.dslot && !dbg_i) |=> !pend_q); // R10

  AST_DROP_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !en_i && !ret_i.valid && !deret_i) |=> drop_q); // R8
endmodule

// File: rtl/ss_gate.sv
`timescale 1ns/1ps
module ss_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_done_i,
  input  logic drop_i,
  input  logic en_i,
  input  logic deret_i,
  output logic fire_o
);
  logic first_q, halt_q;

  assign fire_o = step_done_i & en_i & ~drop_i & ~first_q & ~halt_q & ~deret_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      halt_q  <= 1'b0;
    end else if (deret_i) begin
      first_q <= 1'b1;
      halt_q  <= 1'b0;
    end else begin
      if (step_done_i) first_q <= 1'b0;
      if (fire_o)      halt_q  <= 1'b1;
    end
  end

  AST_QUIET_AFTER_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deret_i |=> !fire_o); // R6

  AST_ONE_PER_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !deret_i) |=> !fire_o); // R7
endmodule

// File: rtl/ss_capture.sv
`timescale 1ns/1ps
module ss_capture #(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [PC_W-1:0] npc_i,
  output logic            exc_o,
  output logic [PC_W-1:0] epc_o,
  output logic            dbd_o
);
  logic            exc_q;
  logic [PC_W-1:0] epc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_q <= 1'b0;
      epc_q <= '0;
    end else begin
      exc_q <= fire_i;
      if (fire_i) epc_q <= npc_i;
    end
  end

  assign exc_o = exc_q;
  assign epc_o = epc_q;
  assign dbd_o = 1'b0;

  AST_EPC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |-> $stable(epc_o)); // R4
endmodule

// File: rtl/single_step_gen.sv
`timescale 1ns/1ps
module single_step_gen
  import ss_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            retire_valid_i,
  input  logic            retire_branch_i,
  input  logic            retire_dslot_i,
  input  logic [PC_W-1:0] retire_next_pc_i,
  input  logic            step_en_i,
  input  logic            debug_mode_i,
  input  logic            deret_i,
  output logic            step_exc_o,
  output logic [PC_W-1:0] step_epc_o,
  output logic            step_dbd_o
);
  retire_t ret;
  logic    step_done, drop, fire;

  assign ret = '{valid: retire_valid_i, branch: retire_branch_i, dslot: retire_dslot_i};

  ss_step_tracker u_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ret_i      (ret),
    .en_i       (step_en_i),
    .dbg_i      (debug_mode_i),
    .deret_i    (deret_i),
    .step_done_o(step_done),
    .drop_o     (drop)
  );

  ss_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_done_i(step_done),
    .drop_i     (drop),
    .en_i       (step_en_i),
    .deret_i    (deret_i),
    .fire_o     (fire)
  );

  ss_capture #(.PC_W(PC_W)) u_capture (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .npc_i (retire_next_pc_i),
    .exc_o (step_exc_o),
    .epc_o (step_epc_o),
    .dbd_o (step_dbd_o)
  );

  AST_EN_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> !step_exc_o); // R1

  AST_DEBUG_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_mode_i |=> !step_exc_o); // R1

  AST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_exc_o |=> !step_exc_o); // R7

  AST_BRANCH_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_i && retire_branch_i && !retire_dslot_i) |=> !step_exc_o); // R3
endmodule

// File: tb/single_step_gen_bench.sv
`timescale 1ns/1ps
module single_step_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rv = 0, rb = 0, rd = 0, en = 0, dbg = 0, dr = 0;
  logic [31:0] npc = '0;
  logic        exc, dbd;
  logic [31:0] epc;

  int n_cmp = 0, n_bad = 0;
  logic        m_pend = 0, m_drop = 0, m_first = 0, m_halt = 0;
  logic        e_exc = 0;
  logic [31:0] e_epc = '0;

  always #2 clk = ~clk;

  single_step_gen #(.PC_W(32)) u_single_step_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .retire_valid_i(rv), .retire_branch_i(rb), .retire_dslot_i(rd),
    .retire_next_pc_i(npc), .step_en_i(en), .debug_mode_i(dbg), .deret_i(dr),
    .step_exc_o(exc), .step_epc_o(epc), .step_dbd_o(dbd)
  );

  task automatic check(input string tag);
    n_cmp++;
    if (exc !== e_exc || epc !== e_epc || dbd !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: exc=%0b epc=%h dbd=%0b expected exc=%0b epc=%h dbd=0",
               tag, exc, epc, dbd, e_exc, e_epc);
    end
  endtask

  // reference model applied at each edge, from the requirements
  task automatic model();
    e_exc = 1'b0;
    if (dr) begin
      m_pend = 0; m_drop = 0; m_halt = 0; m_first = 1;
    end else begin
      if (m_pend && !en) m_drop = 1;
      if (rv && !dbg) begin
        if (rb && !rd) begin
          m_pend = 1; m_drop = !en;
        end else begin
          if (en && !m_drop && !m_first && !m_halt) begin
            e_exc = 1; e_epc = npc; m_halt = 1;
          end
          m_first = 0; m_pend = 0; m_drop = 0;
        end
      end
    end
  endtask

  task automatic cyc(input logic v, b, d, e, g, r, input logic [31:0] np, input string tag);
    rv = v; rb = b; rd = d; en = e; dbg = g; dr = r; npc = np;
    @(posedge clk);
    model();
    @(negedge clk);
    check(tag);
  endtask

  task automatic ret_from_debug(input string tag);
    cyc(0, 0, 0, 1, 1, 0, 32'h0, tag);
    cyc(0, 0, 0, 1, 1, 1, 32'h0, tag);
    cyc(0, 0, 0, 1, 0, 0, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset");
    rst_n = 1'b1;
    // R9: no first-step suppression out of reset; R2 plain step
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_1004, "R2 R9 plain step fires");
    cyc(0, 0, 0, 1, 0, 0, 32'h0000_2000, "R7 pulse ends");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_1008, "R7 no second request");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_100c, "R4 epc held");
    // R6
    ret_from_debug("R6 return");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_3004, "R6 first step quiet");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_3008, "R6 second step fires");
    // R3 branch plus slot
    ret_from_debug("R3 return");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_4004, "R3 first");
    cyc(1, 1, 0, 1, 0, 0, 32'h0000_4008, "R3 branch no request");
    cyc(1, 0, 1, 1, 0, 0, 32'h0000_8000, "R3 slot closes to target");
    cyc(0, 0, 0, 1, 0, 0, 32'h0, "R3 idle");
    // R8
    ret_from_debug("R8 return");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_5004, "R8 first");
    cyc(1, 1, 0, 1, 0, 0, 32'h0000_5008, "R8 branch");
    cyc(0, 0, 0, 0, 0, 0, 32'h0, "R8 enable dropped");
    cyc(1, 0, 1, 1, 0, 0, 32'h0000_9000, "R8 step suppressed");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_9004, "R8 next step fires");
    // R10
    ret_from_debug("R10 return");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_6004, "R10 first");
    cyc(1, 0, 1, 1, 0, 0, 32'h0000_6008, "R10 lone slot closes");
    ret_from_debug("R10 return2");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_6104, "R10 first2");
    cyc(1, 1, 1, 1, 0, 0, 32'h0000_6108, "R10 slot overrides branch");
    // R1
    ret_from_debug("R1 return");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_7004, "R1 first");
    cyc(1, 0, 0, 0, 0, 0, 32'h0000_7008, "R1 disabled step");
    cyc(1, 0, 0, 1, 1, 0, 32'h0000_700c, "R1 debug mode retire ignored");
    cyc(1, 1, 0, 1, 1, 0, 32'h0000_7010, "R1 debug mode branch ignored");
    cyc(1, 0, 0, 1, 0, 0, 32'h0000_7014, "R1 enabled step fires");
    // R3 R8 sweep: optional gap, enable pattern over branch/gap/slot
    for (int g = 0; g < 2; g++) begin
      for (int m = 0; m < 8; m++) begin
        ret_from_debug("R3 R8 sweep return");
        cyc(1, 0, 0, 1, 0, 0, 32'h0001_0000 + 32'(m), "R6 sweep first");
        cyc(1, 1, 0, m[0], 0, 0, 32'h0002_0000 + 32'(m), "R3 sweep branch");
        if (g == 1) cyc(0, 0, 0, m[1], 0, 0, 32'h0, "R8 sweep gap");
        cyc(1, 0, 1, m[2], 0, 0, 32'h0003_0000 + 32'(m << 4) + 32'(g), "R3 R8 sweep slot");
        cyc(1, 0, 0, 1, 0, 0, 32'h0004_0000 + 32'(m), "R7 R8 sweep trailing");
        cyc(0, 0, 0, 1, 0, 0, 32'h0, "R5 R7 sweep idle");
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule